// File: doc/BRIEF.md
# Cell Balancing Bank Sequencer

This block sequences the balancing switches of a six-cell series stack. The cells form two banks: cells 1, 3 and 5 are the odd bank, and cells 2, 4 and 6 are the even bank. Each cell has its own countdown timer. Each cell also has a flag from an external comparator that goes high when the cell has discharged to its target voltage. A single-cycle start strobe latches the whole configuration, clears the per-cell done flags and begins a balancing cycle. The configuration is the per-cell times, a two-bit sequence code, a duty period and a fault-stop enable. From then on the block runs on its own until the cycle is over, so the host can stay idle.

The sequence code picks which banks take part and in what order. With a duty period of zero, one bank runs to completion before the other starts. With a non-zero duty period, the block swaps the active bank each time that many timebase ticks have elapsed, and it never swaps onto a bank that has already finished. A pause input freezes the sequencer and forces every switch off. A fault input ends the cycle early when fault-stop was latched, but a fault is only acted on while the block is not paused. All control and status pins are plain level or strobe signals, with no handshake.

Top module: `cb_bank_seq`

## Requirements
- R1: A high `go_i` in a clock cycle latches `cell_time_i`, `seq_mode_i`, `duty_i` and `fault_stop_i`. Changes to these inputs after that edge have no effect on the running cycle.
- R2: `run_o` rises on the edge after `go_i`. It stays high through the whole cycle, including paused intervals, and falls on the same edge on which `all_done_o` rises. The two are never high together.
- R3: Switch `sw_en_o[i]` is high only while cell i+1 is selected, its bank is active, the block is running and not paused, its done flag is low and its timer is non-zero. Each timebase tick decrements the timers of the active, unfinished cells. A cell whose timer reaches zero, or whose `under_thr_i` bit is high while its bank is active, sets `done_o[i]` on the next edge. The other cells keep balancing.
- R4: With `duty_i` = 0, the block moves to the second bank only after every selected cell of the first bank is done. Code 2'b10 runs the odd bank (bits 0, 2, 4) first. Code 2'b11 runs the even bank (bits 1, 3, 5) first. `all_done_o` rises one edge after the last selected done flag is set.
- R5: A selected cell latched with time 0 never turns its switch on. Its done flag is set on the second edge after `go_i`.
- R6: Code 2'b00 runs only the even bank and 2'b01 runs only the odd bank. All done flags clear on `go_i`, and the flags of an unselected bank stay 0. A complete odd-only cycle leaves `done_o` = 6'h15, and a complete even-only cycle leaves 6'h2A.
- R7: With `duty_i` = D > 0 and both banks selected, the active bank swaps on every D-th tick counted from the start of the cycle. The switch pattern after j ticks is therefore the first bank's pattern when floor(j/D) is even, and the other bank's pattern otherwise.
- R8: In duty mode, the block does not swap onto a bank whose selected cells are all done. It stays on the unfinished bank until that bank completes.
- R9: While `pause_i` is high during a cycle, all switches are off, `paused_o` is high, and timers, done flags and bank state hold their values. Ticks arriving during a pause are lost.
- R10: A fault present only during a pause has no effect. If `fault_i` is still high when `pause_i` falls, the fault-stop rule applies at that edge.
- R11: With fault-stop latched as 1, a fault while running and not paused turns all switches off in that cycle and ends the cycle at the next edge: `run_o` falls, `all_done_o` rises, and the done flags keep their values. With fault-stop latched as 0, `fault_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_i | input | 1 | Start strobe; latches configuration and begins a cycle |
| cell_time_i | input | 48 | Per-cell times in ticks, 8 bits each, cell 1 in bits 7:0 |
| seq_mode_i | input | 2 | 00 even only, 01 odd only, 10 odd then even, 11 even then odd |
| duty_i | input | 4 | Duty period in ticks; 0 selects bank-after-bank mode |
| fault_stop_i | input | 1 | Fault-stop enable |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| pause_i | input | 1 | Pause control, level |
| fault_i | input | 1 | Fault indication, level |
| under_thr_i | input | 6 | Per-cell at-threshold flags |
| sw_en_o | output | 6 | Per-cell balancing switch enables |
| done_o | output | 6 | Per-cell done flags |
| run_o | output | 1 | Balancing cycle in progress |
| all_done_o | output | 1 | Cycle finished, or stopped by a fault |
| paused_o | output | 1 | Cycle is paused |

## Verification
The bench sweeps a zero time over every cell position in both single-bank modes. A design that left a zero-time switch on for a cycle, or set the flag of the wrong bank, shows up there. It steps every duty period from 1 to 3 through six ticks and compares the bank pattern with floor(j/D). An off-by-one in the duty count, or a counter that is not cleared on `go_i`, shifts the pattern. Other cases arrange for one bank to finish in the middle of a duty period. A sequencer that swapped back onto the finished bank would show a dark switch pattern. Further cases count ticks across a pause, to catch timers that kept running or faults that acted while paused. Finally, the bench rewrites the configuration during a cycle, which exposes any input read live rather than latched.

// File: rtl/cb_pkg.sv
package cb_pkg;

  typedef enum logic [1:0] {
    SEQ_EVEN_ONLY  = 2'b00,
    SEQ_ODD_ONLY   = 2'b01,
    SEQ_ODD_FIRST  = 2'b10,
    SEQ_EVEN_FIRST = 2'b11
  } seq_mode_e;

  // Cell i+1 sits on bit i; bits 0, 2, 4 ... form the odd bank.
  function automatic logic [63:0] odd_bank_mask(input int n);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < n && i < 64; i += 2) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] even_bank_mask(input int n);
    logic [63:0] m;
    m = '0;
    for (int i = 1; i < n && i < 64; i += 2) m[i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/cb_cell_lane.sv
module cb_cell_lane #(
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              sel_i,
  input  logic              active_i,
  input  logic              run_en_i,
  input  logic              tick_i,
  input  logic              under_i,
  output logic              done_o,
  output logic              sw_o
);

  logic [TIME_W-1:0] timer_q;
  logic              done_q;
  logic              live;

  assign live = run_en_i & sel_i & ~done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= '0;
      done_q  <= 1'b0;
    end else if (load_i) begin
      timer_q <= time_i;
      done_q  <= 1'b0;
    end else if (live) begin
      if (timer_q == '0) begin
        done_q <= 1'b1;
      end else if (active_i && under_i) begin
        done_q <= 1'b1;
      end else if (active_i && tick_i) begin
        timer_q <= timer_q - 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign sw_o   = live & active_i & (timer_q != '0);

endmodule

// File: rtl/cb_bank_ctrl.sv
module cb_bank_ctrl
  import cb_pkg::*;
#(
  parameter int NUM_CELLS = 6,
  parameter int DUTY_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go_i,
  input  logic [1:0]           seq_mode_i,
  input  logic [DUTY_W-1:0]    duty_i,
  input  logic                 fault_stop_i,
  input  logic                 tick_i,
  input  logic                 pause_i,
  input  logic                 fault_i,
  input  logic [NUM_CELLS-1:0] done_i,
  output logic [NUM_CELLS-1:0] sel_mask_o,
  output logic [NUM_CELLS-1:0] act_mask_o,
  output logic                 run_en_o,
  output logic                 run_o,
  output logic                 all_done_o,
  output logic                 paused_o
);

  localparam logic [NUM_CELLS-1:0] ODD_M  = NUM_CELLS'(odd_bank_mask(NUM_CELLS));
  localparam logic [NUM_CELLS-1:0] EVEN_M = NUM_CELLS'(even_bank_mask(NUM_CELLS));

  seq_mode_e         seq_q;
  logic [DUTY_W-1:0] duty_q;
  logic [DUTY_W-1:0] cnt_q;
  logic              fstop_q;
  logic              run_q;
  logic              fin_q;
  logic              on_even_q;

  logic odd_fin, even_fin, all_fin, cur_fin, oth_fin, stop_now, period_end;

  always_comb begin
    sel_mask_o = '0;
    if (seq_q != SEQ_EVEN_ONLY) sel_mask_o = sel_mask_o | ODD_M;
    if (seq_q != SEQ_ODD_ONLY)  sel_mask_o = sel_mask_o | EVEN_M;
  end

  assign odd_fin    = &(done_i | ~(sel_mask_o & ODD_M));
  assign even_fin   = &(done_i | ~(sel_mask_o & EVEN_M));
  assign all_fin    = odd_fin & even_fin;
  assign cur_fin    = on_even_q ? even_fin : odd_fin;
  assign oth_fin    = on_even_q ? odd_fin : even_fin;
  assign stop_now   = fault_i & fstop_q;
  assign period_end = (duty_q != '0) && tick_i && (cnt_q == duty_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q     <= SEQ_EVEN_ONLY;
      duty_q    <= '0;
      cnt_q     <= '0;
      fstop_q   <= 1'b0;
      run_q     <= 1'b0;
      fin_q     <= 1'b0;
      on_even_q <= 1'b0;
    end else if (go_i) begin
      seq_q     <= seq_mode_e'(seq_mode_i);
      duty_q    <= duty_i;
      fstop_q   <= fault_stop_i;
      cnt_q     <= '0;
      run_q     <= 1'b1;
      fin_q     <= 1'b0;
      on_even_q <= (seq_mode_i == SEQ_EVEN_ONLY) || (seq_mode_i == SEQ_EVEN_FIRST);
    end else if (run_q && !pause_i) begin
      if (stop_now || all_fin) begin
        run_q <= 1'b0;
        fin_q <= 1'b1;
      end else if (cur_fin) begin
        on_even_q <= ~on_even_q;
        cnt_q     <= '0;
      end else if (duty_q != '0 && tick_i) begin
        if (period_end) begin
          cnt_q <= '0;
          if (!oth_fin) on_even_q <= ~on_even_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign act_mask_o = on_even_q ? EVEN_M : ODD_M;
  assign run_en_o   = run_q & ~pause_i & ~stop_now;
  assign run_o      = run_q;
  assign all_done_o = fin_q;
  assign paused_o   = run_q & pause_i;

endmodule

// File: rtl/cb_bank_seq.sv
module cb_bank_seq
  import cb_pkg::*;
#(
  parameter int NUM_CELLS = 6,
  parameter int TIME_W    = 8,
  parameter int DUTY_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        go_i,
  input  logic [NUM_CELLS*TIME_W-1:0] cell_time_i,
  input  logic [1:0]                  seq_mode_i,
  input  logic [DUTY_W-1:0]           duty_i,
  input  logic                        fault_stop_i,
  input  logic                        tick_i,
  input  logic                        pause_i,
  input  logic                        fault_i,
  input  logic [NUM_CELLS-1:0]        under_thr_i,
  output logic [NUM_CELLS-1:0]        sw_en_o,
  output logic [NUM_CELLS-1:0]        done_o,
  output logic                        run_o,
  output logic                        all_done_o,
  output logic                        paused_o
);

  logic [NUM_CELLS-1:0] sel_mask;
  logic [NUM_CELLS-1:0] act_mask;
  logic                 run_en;

  cb_bank_ctrl #(
    .NUM_CELLS(NUM_CELLS),
    .DUTY_W   (DUTY_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (go_i),
    .seq_mode_i  (seq_mode_i),
    .duty_i      (duty_i),
    .fault_stop_i(fault_stop_i),
    .tick_i      (tick_i),
    .pause_i     (pause_i),
    .fault_i     (fault_i),
    .done_i      (done_o),
    .sel_mask_o  (sel_mask),
    .act_mask_o  (act_mask),
    .run_en_o    (run_en),
    .run_o       (run_o),
    .all_done_o  (all_done_o),
    .paused_o    (paused_o)
  );

  for (genvar g = 0; g < NUM_CELLS; g++) begin : g_lane
    cb_cell_lane #(
      .TIME_W(TIME_W)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (go_i),
      .time_i  (cell_time_i[g*TIME_W +: TIME_W]),
      .sel_i   (sel_mask[g]),
      .active_i(act_mask[g]),
      .run_en_i(run_en),
      .tick_i  (tick_i),
      .under_i (under_thr_i[g]),
      .done_o  (done_o[g]),
      .sw_o    (sw_en_o[g])
    );
  end

endmodule

// File: rtl/cb_bank_seq_sva.sv
module cb_bank_seq_sva
  import cb_pkg::*;
#(
  parameter int NUM_CELLS = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 go_i,
  input logic                 pause_i,
  input logic [NUM_CELLS-1:0] sw_en_o,
  input logic [NUM_CELLS-1:0] done_o,
  input logic                 run_o,
  input logic                 all_done_o,
  input logic                 paused_o
);

  localparam logic [NUM_CELLS-1:0] ODD_M  = NUM_CELLS'(odd_bank_mask(NUM_CELLS));
  localparam logic [NUM_CELLS-1:0] EVEN_M = NUM_CELLS'(even_bank_mask(NUM_CELLS));

  // R2: run and overall done never together
  a_r2_run_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_o && all_done_o));

  // R2: overall done rises exactly as run falls
  a_r2_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(all_done_o) |-> $fell(run_o));

  // R3: a finished cell never has its switch on
  a_r3_done_sw_off: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en_o & done_o) == '0);

  // R7: switches come from one bank only
  a_r7_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_en_o & ODD_M) == '0) || ((sw_en_o & EVEN_M) == '0));

  // R9: pause forces every switch off
  a_r9_pause_dark: assert property (@(posedge clk) disable iff (!rst_n)
    pause_i |-> (sw_en_o == '0));

  // R9: paused cycle holds done flags and stays running
  a_r9_pause_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (paused_o && !go_i) |=> ($stable(done_o) && run_o));

  // R1: outside a cycle done flags change only through go
  a_r1_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && !go_i) |=> $stable(done_o));

endmodule

bind cb_bank_seq cb_bank_seq_sva #(.NUM_CELLS(NUM_CELLS)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .go_i      (go_i),
  .pause_i   (pause_i),
  .sw_en_o   (sw_en_o),
  .done_o    (done_o),
  .run_o     (run_o),
  .all_done_o(all_done_o),
  .paused_o  (paused_o)
);

// File: tb/cb_bank_seq_tb.sv
`timescale 1ns/1ps
module cb_bank_seq_tb;

  localparam int N = 6;
  localparam int TW = 8;
  localparam logic [5:0] ODD = 6'h15;
  localparam logic [5:0] EVN = 6'h2A;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          go = 1'b0;
  logic [N*TW-1:0] times = '0;
  logic [1:0]    seq = 2'b00;
  logic [3:0]    duty = 4'd0;
  logic          fstop = 1'b0;
  logic          tick = 1'b0;
  logic          pause = 1'b0;
  logic          fault = 1'b0;
  logic [N-1:0]  under = '0;
  logic [N-1:0]  sw, done;
  logic          run, adone, paused;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  cb_bank_seq u_dut (
    .clk(clk), .rst_n(rst_n), .go_i(go), .cell_time_i(times), .seq_mode_i(seq),
    .duty_i(duty), .fault_stop_i(fstop), .tick_i(tick), .pause_i(pause),
    .fault_i(fault), .under_thr_i(under), .sw_en_o(sw), .done_o(done),
    .run_o(run), .all_done_o(adone), .paused_o(paused)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_all(input logic [7:0] v);
    for (int i = 0; i < N; i++) times[i*TW +: TW] = v;
  endtask

  task automatic start();
    go = 1'b1;
    step(1);
    go = 1'b0;
  endtask

  task automatic tick1();
    tick = 1'b1;
    step(1);
    tick = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    chk("R2 reset run", run, 0);
    chk("R2 reset done", adone, 0);
    chk("R3 reset sw", sw, 0);
    chk("R6 reset flags", done, 0);
    rst_n = 1'b1;
    step(1);

    // R6 / R4: every sequence code, all times 1
    for (int m = 0; m < 4; m++) begin
      logic [5:0] first, all;
      first = (m == 0 || m == 3) ? EVN : ODD;
      all   = (m == 0) ? EVN : (m == 1) ? ODD : 6'h3F;
      seq = m[1:0]; duty = 0; set_all(8'd1);
      start();
      chk("R2 run after go", run, 1);
      chk("R4 first bank", sw, first);
      tick1(); step(3);
      if (m >= 2) chk("R4 second bank", sw, all & ~first);
      tick1(); step(3);
      chk("R6 final flags", done, all);
      chk("R2 all done", adone, 1);
      chk("R2 run cleared", run, 0);
    end

    // R5: zero time swept over every cell in single-bank modes
    for (int c = 0; c < N; c++) begin
      logic [5:0] bm;
      bm = (c % 2 == 0) ? ODD : EVN;
      seq = (c % 2 == 0) ? 2'b01 : 2'b00; duty = 0; set_all(8'd2);
      times[c*TW +: TW] = 8'd0;
      start();
      chk("R5 zero cell dark", sw, bm & ~(6'(1) << c));
      step(1);
      chk("R5 zero cell done", done, 6'(1) << c);
    end

    // R3: under-threshold on cell 2 in even-only mode
    seq = 2'b00; duty = 0; set_all(8'd5);
    start();
    under = 6'h02;
    step(1);
    under = 6'h00;
    chk("R3 under done", done, 6'h02);
    chk("R3 others continue", sw, 6'h28);

    // R7: duty period sweep, even bank first
    for (int d = 1; d <= 3; d++) begin
      seq = 2'b11; duty = 4'(d); set_all(8'd20);
      start();
      chk("R7 initial bank", sw, EVN);
      for (int j = 1; j <= 6; j++) begin
        tick1();
        chk("R7 duty bank", sw, ((j / d) % 2 == 0) ? EVN : ODD);
      end
    end

    // R8: odd finishes first, no swap back onto it
    seq = 2'b10; duty = 4'd1;
    for (int i = 0; i < N; i++) times[i*TW +: TW] = (i % 2 == 0) ? 8'd2 : 8'd5;
    start();
    tick1(); tick1(); tick1();
    step(1);
    chk("R8 odd flags", done, ODD);
    tick1();
    chk("R8 stays even", sw, EVN);
    tick1();
    chk("R8 still even", sw, EVN);
    tick1(); tick1(); step(3);
    chk("R8 complete", done, 6'h3F);
    chk("R8 all done", adone, 1);

    // R9: pause freezes and loses ticks
    seq = 2'b01; duty = 0; set_all(8'd3);
    start();
    tick1();
    pause = 1'b1;
    step(1);
    chk("R9 dark", sw, 0);
    chk("R9 status", paused, 1);
    chk("R2 run while paused", run, 1);
    tick1(); tick1();
    pause = 1'b0;
    step(1);
    chk("R9 resumed", sw, ODD);
    tick1(); step(2);
    chk("R9 ticks lost", adone, 0);
    tick1(); step(3);
    chk("R9 finish", done, ODD);

    // R10 / R11: fault during pause, still present at release
    seq = 2'b01; duty = 0; fstop = 1'b1; set_all(8'd4);
    start();
    tick1();
    pause = 1'b1; step(1);
    fault = 1'b1; step(2);
    chk("R10 ignored in pause", run, 1);
    chk("R10 no done in pause", adone, 0);
    pause = 1'b0;
    step(1);
    chk("R11 stopped", adone, 1);
    chk("R11 run low", run, 0);
    chk("R11 dark", sw, 0);
    chk("R11 flags kept", done, 0);
    fault = 1'b0; fstop = 1'b0;

    // R11: fault-stop disabled
    seq = 2'b00; duty = 0; fstop = 1'b0; set_all(8'd2);
    fault = 1'b1;
    start();
    chk("R11 no effect sw", sw, EVN);
    tick1(); tick1(); step(3);
    chk("R11 normal finish", done, EVN);
    fault = 1'b0;

    // R1: configuration changes during a cycle ignored
    seq = 2'b10; duty = 0; set_all(8'd2);
    start();
    seq = 2'b00; duty = 4'd1; set_all(8'd0);
    tick1();
    chk("R1 bank unchanged", sw, ODD);
    tick1(); step(2);
    chk("R1 order kept", sw, EVN);
    tick1(); tick1(); step(3);
    chk("R1 full result", done, 6'h3F);

    // R6: unselected flags cleared on go
    seq = 2'b01; set_all(8'd2);
    start();
    chk("R6 cleared on go", done, 0);
    tick1(); tick1(); step(3);
    chk("R6 odd only result", done, 6'h15);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule